// File: doc/BRIEF.md
# SPI Memory Read Sequencer

This block is the read side of a serial memory that sits on an SPI bus as a target. A host lowers the active-low select, clocks in one command byte and a 16-bit address, and then keeps clocking to pull data bytes out. The block fetches each byte from a synchronous memory port with a one-cycle read latency. It shifts the byte out most significant bit first, then moves on to the next address. This continues for as long as select stays low.

The serial inputs are brought into the block's own clock domain through synchronizers, and the serial clock edges are found there. For that reason the serial clock must be at least eight times slower than the block clock, with each half period lasting at least four block clock cycles. The data line is driven only while bytes are being streamed. At all other times it is released to high impedance, and `spi_miso_en` reports whether it is driven.

Top module: `spi_rd_seq`

## Requirements
- R1: A transaction starts when `spi_cs_n` goes low. The first 8 bits, sampled on rising `spi_sclk` edges with the most significant bit first, form the command byte.
- R2: After a read command (0x03), the next 16 rising edges shift in the address, most significant bit first. The first memory read (`mem_rd_en` high for one cycle) is issued to exactly that address.
- R3: Data bits change only after falling `spi_sclk` edges (mode 0). The most significant bit of the first byte is valid on `spi_miso` after the falling edge that follows the 24th rising edge. Each byte is sent most significant bit first and equals the memory word read one cycle after its request.
- R4: While select stays low, each following byte comes from the previous address plus one, with no gap between bytes. The read for the next byte is issued once the last bit of the current byte has been shifted out. A transaction that streams N bytes therefore issues N+1 reads, and no two reads fall on adjacent cycles.
- R5: `spi_miso_en` is low, and `spi_miso` is high impedance, throughout the command and address phases.
- R6: A command byte other than 0x03 keeps `spi_miso_en` low and issues no memory read until select rises. A bit-reversed read code (0xC0) counts as such a command.
- R7: During streaming, the address wraps from 0xFFFF to 0x0000.
- R8: When select rises, `spi_miso_en` drops in the same instant. The transaction is abandoned and the bit counter is cleared, so the next transaction decodes correctly even if the abort came in the middle of the address or a data byte.
- R9: After reset, `spi_miso_en` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; memory port is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when not driven |
| spi_miso_en | output | 1 | High while `spi_miso` is driven |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |

## Verification
The bench reads from an address near the top of the space and follows the stream across 0xFFFF. A design that fails to wrap would either stall there or read outside the 16-bit range. It aborts one transaction part-way through the address and another part-way through a data byte, then starts a clean read. A bit counter that survives an abort would misplace the opcode and return the wrong bytes. It sends an unknown opcode and a bit-reversed read opcode and requires silence and zero memory traffic, which catches a decoder that takes bits in the wrong order or ignores the opcode. Every byte is compared against the memory pattern, and the exact number and order of reads is checked, which catches an off-by-one first fetch or a skipped increment.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
    // positions of the serial pins inside the synchronizer vector
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_DI  = 2;
    localparam int PIN_CNT = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_SKIP = 3'd4
    } st_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int           W        = 3,
    parameter int           STAGES   = 2,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter int           EDGE_IDX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         rise_o,
    output logic         fall_o
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[gi]}};
                else        chain_q <= {chain_q[STAGES-2:0], async_i[gi]};
            end
            assign sync_o[gi] = chain_q[STAGES-1];
        end
    endgenerate

    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL[EDGE_IDX];
        else        prev_q <= sync_o[EDGE_IDX];
    end

    assign rise_o =  sync_o[EDGE_IDX] & ~prev_q;
    assign fall_o = ~sync_o[EDGE_IDX] &  prev_q;
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int              CMD_W   = 8,
    parameter int              ADDR_W  = 16,
    parameter logic [CMD_W-1:0] READ_OP = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_rise,
    input  logic              di_s,
    input  logic              byte_done,
    output st_e               st_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_vld_o
);
    localparam int CNT_W = $clog2(ADDR_W) + 1;
    localparam int SH_W  = ADDR_W - 1;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
        logic [ADDR_W-1:0] addr;
        logic              rd_en;
        logic              rd_vld;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_IDLE, cnt: '0, sh: '0, addr: '0,
                                   rd_en: 1'b0, rd_vld: 1'b0};

    ctrl_t q, d;

    always_comb begin
        d        = q;
        d.rd_en  = 1'b0;
        d.rd_vld = q.rd_en;
        if (cs_n_s) begin
            d.st     = ST_IDLE;
            d.cnt    = '0;
            d.rd_vld = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE, ST_CMD: begin
                    d.st = ST_CMD;
                    if (sck_rise) begin
                        d.sh = {q.sh[SH_W-2:0], di_s};
                        if (q.cnt == CNT_W'(CMD_W - 1)) begin
                            d.cnt = '0;
                            d.st  = ({q.sh[CMD_W-2:0], di_s} == READ_OP) ? ST_ADDR : ST_SKIP;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        d.sh = {q.sh[SH_W-2:0], di_s};
                        if (q.cnt == CNT_W'(ADDR_W - 1)) begin
                            d.cnt   = '0;
                            d.addr  = {q.sh, di_s};
                            d.rd_en = 1'b1;
                            d.st    = ST_DATA;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        d.addr  = q.addr + 1'b1;
                        d.rd_en = 1'b1;
                    end
                end
                default: begin
                    // unknown command: stay silent until deselect
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign st_o      = q.st;
    assign rd_en_o   = q.rd_en;
    assign rd_addr_o = q.addr;
    assign rd_vld_o  = q.rd_vld;
endmodule

// File: rtl/spi_rd_txshift.sv
module spi_rd_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_fall,
    input  logic              load_vld,
    input  logic [DATA_W-1:0] load_data,
    output logic              bit_o,
    output logic              oe_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              bitv;
        logic              oe;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } tx_t;

    localparam tx_t TX_RST = '{sh: '0, bitv: 1'b0, oe: 1'b0, cnt: '0, done: 1'b0};

    tx_t q, d;
    logic [DATA_W-1:0] src;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        src    = load_vld ? load_data : q.sh;
        if (!active) begin
            d = TX_RST;
        end else begin
            d.sh = src;
            if (sck_fall) begin
                d.bitv = src[DATA_W-1];
                d.sh   = {src[DATA_W-2:0], 1'b0};
                d.oe   = 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) begin
                    d.cnt  = '0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

    assign bit_o  = q.bitv;
    assign oe_o   = q.oe;
    assign done_o = q.done;
endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
    import spi_rd_pkg::*;
#(
    parameter int               CMD_W       = 8,
    parameter int               ADDR_W      = 16,
    parameter int               DATA_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CMD_W-1:0] READ_OP     = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic               sck_rise;
    logic               sck_fall;
    st_e                ctrl_st;
    logic               rd_vld;
    logic               tx_bit;
    logic               tx_oe;
    logic               tx_done;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_CS]  = spi_cs_n;
        pins_raw[PIN_SCK] = spi_sclk;
        pins_raw[PIN_DI]  = spi_mosi;
    end

    spi_rd_sync #(
        .W        (PIN_CNT),
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (PIN_CNT'(1) << PIN_CS),
        .EDGE_IDX (PIN_SCK)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s),
        .rise_o  (sck_rise),
        .fall_o  (sck_fall)
    );

    spi_rd_ctrl #(
        .CMD_W   (CMD_W),
        .ADDR_W  (ADDR_W),
        .READ_OP (READ_OP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[PIN_CS]),
        .sck_rise  (sck_rise),
        .di_s      (pins_s[PIN_DI]),
        .byte_done (tx_done),
        .st_o      (ctrl_st),
        .rd_en_o   (mem_rd_en),
        .rd_addr_o (mem_addr),
        .rd_vld_o  (rd_vld)
    );

    spi_rd_txshift #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (ctrl_st == ST_DATA),
        .sck_fall  (sck_fall),
        .load_vld  (rd_vld),
        .load_data (mem_rd_data),
        .bit_o     (tx_bit),
        .oe_o      (tx_oe),
        .done_o    (tx_done)
    );

    // raw select gates the driver so a deselect releases the line at once
    assign spi_miso_en = tx_oe & ~spi_cs_n;
    assign spi_miso    = spi_miso_en ? tx_bit : 1'bz;
endmodule

// File: rtl/spi_rd_seq_chk.sv
module spi_rd_seq_chk
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso_en,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input st_e               st,
    input logic              sck_fall,
    input logic              miso_bit
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;
    logic [2:0]        hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            last_q   <= '0;
            hi_cnt_q <= '0;
        end else begin
            if (spi_cs_n) begin
                seen_q <= 1'b0;
                if (hi_cnt_q != 3'd7) hi_cnt_q <= hi_cnt_q + 1'b1;
            end else begin
                hi_cnt_q <= '0;
                if (mem_rd_en) begin
                    seen_q <= 1'b1;
                    last_q <= mem_addr;
                end
            end
        end
    end

    assert_rd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && seen_q && !spi_cs_n) |-> (mem_addr == last_q + 1'b1));

    assert_addr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && seen_q && !spi_cs_n && (last_q == '1)) |-> (mem_addr == '0));

    assert_quiet_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_en |-> (st == ST_DATA));

    assert_skip_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> (!spi_miso_en && !mem_rd_en));

    assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q >= 3'd4) |-> (st == ST_IDLE && !spi_miso_en));

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) == ST_DATA && !$past(sck_fall)) |-> $stable(miso_bit));
endmodule

bind spi_rd_seq spi_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_en (spi_miso_en),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .st          (ctrl_st),
    .sck_fall    (sck_fall),
    .miso_bit    (tx_bit)
);

// File: tb/spi_rd_seq_test.sv
`timescale 1ns/1ps
module spi_rd_seq_test;
    localparam int HALF = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    wire         miso;
    logic        miso_en;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h00;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_cnt = 0;
    logic [15:0] rd_log [0:63];

    always #2 clk = ~clk;

    spi_rd_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_en (miso_en),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= pattern(mem_addr);
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] val, input int n, inout bit drove);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = val[i];
            #HALF;
            if (miso_en) drove = 1'b1;
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic recv_bits(input int n, output logic [7:0] b, inout bit off);
        b = 8'h00;
        for (int i = 0; i < n; i++) begin
            mosi = 1'b0;
            #HALF;
            if (!miso_en) off = 1'b1;
            b = {b[6:0], miso};
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic finish_txn();
        #HALF;
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic do_read(input logic [15:0] addr, input int n);
        int          base;
        bit          drove;
        bit          off;
        logic [7:0]  b;
        logic [15:0] a;
        base  = rd_cnt;
        drove = 1'b0;
        off   = 1'b0;
        cs_n  = 1'b0;
        #HALF;
        send_bits(32'h03, 8, drove);
        send_bits({16'h0, addr}, 16, drove);
        chk(!drove, "R5", "line driven during command/address", int'(drove), 0);
        for (int k = 0; k < n; k++) begin
            a = addr + 16'(k);
            recv_bits(8, b, off);
            chk(b == pattern(a), (k == 0) ? "R3" : "R4", "streamed byte", b, pattern(a));
        end
        chk(!off, "R3", "line released while streaming", int'(off), 0);
        finish_txn();
        chk(rd_cnt - base == n + 1, "R4", "read count", rd_cnt - base, n + 1);
        chk(rd_log[base % 64] == addr, "R2", "first read address", rd_log[base % 64], addr);
        chk(rd_log[(base + n) % 64] == 16'(addr + 16'(n)), "R4", "prefetch address",
            rd_log[(base + n) % 64], 16'(addr + 16'(n)));
        chk(rd_cnt > base, "R1", "read command accepted after select fall", rd_cnt - base, n + 1);
    endtask

    task automatic test_reset();
        chk(miso_en == 1'b0, "R9", "driver enable after reset", miso_en, 0);
        chk(mem_rd_en == 1'b0, "R9", "read request after reset", mem_rd_en, 0);
    endtask

    task automatic test_plain_read();
        do_read(16'h1234, 4);
    endtask

    task automatic test_wrap();
        logic [15:0] a;
        a = 16'hFFFE;
        do_read(a, 3);
        chk(rd_log[(rd_cnt - 2) % 64] == 16'h0000, "R7", "address after 0xFFFF",
            rd_log[(rd_cnt - 2) % 64], 16'h0000);
    endtask

    task automatic test_bad_op(input logic [7:0] op);
        int base;
        bit drove;
        base  = rd_cnt;
        drove = 1'b0;
        cs_n  = 1'b0;
        #HALF;
        send_bits({24'h0, op}, 8, drove);
        send_bits(32'hA5C3_0F0F, 32, drove);
        finish_txn();
        chk(!drove, "R6", "line driven after unknown command", int'(drove), 0);
        chk(rd_cnt == base, "R6", "reads after unknown command", rd_cnt - base, 0);
    endtask

    task automatic test_abort_addr();
        bit drove;
        drove = 1'b0;
        cs_n  = 1'b0;
        #HALF;
        send_bits(32'h03, 8, drove);
        send_bits(32'h0ABC, 12, drove);
        #HALF;
        cs_n = 1'b1;
        #(4 * HALF);
        chk(!miso_en, "R8", "enable after abort in address", miso_en, 0);
        do_read(16'h00A5, 2);
    endtask

    task automatic test_abort_data();
        bit         drove;
        bit         off;
        logic [7:0] b;
        drove = 1'b0;
        off   = 1'b0;
        cs_n  = 1'b0;
        #HALF;
        send_bits(32'h03, 8, drove);
        send_bits(32'h4000, 16, drove);
        recv_bits(8, b, off);
        chk(b == pattern(16'h4000), "R3", "byte before abort", b, pattern(16'h4000));
        recv_bits(3, b, off);
        #HALF;
        chk(miso_en, "R8", "enable before deselect", miso_en, 1);
        cs_n = 1'b1;
        #1;
        chk(!miso_en, "R8", "enable right after deselect", miso_en, 0);
        #(4 * HALF);
        do_read(16'h7FF0, 2);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        test_reset();
        @(posedge clk);
        #1;
        #(2 * HALF);
        test_plain_read();
        test_wrap();
        test_bad_op(8'h0B);
        test_bad_op(8'hC0);
        test_abort_addr();
        test_abort_data();
        test_plain_read();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule